// File: doc/BRIEF.md
# Absolute-Difference Adder/Subtractor

This block adds two unsigned operands or, in subtract mode, returns the unsigned distance between them, |A−B|, in place of a wrapped two's-complement difference. It is built from two identical arithmetic stages. Each stage is a bank of controllable inverters feeding a ripple-carry adder. Every XOR in the design is made only of three-input majority functions and inversion, the same way that cellular-logic fabrics build XOR.

Stage one forms A+B, or A plus the inverted B plus one. In subtract mode, a low carry from stage one means B was larger. In that case stage two negates the stage-one value by inverting it and adding one. Otherwise stage two passes the value through unchanged. In add mode the top carry is dropped.

A register follows each stage, so an operand pair accepted with `in_valid` produces its result two clock edges later, together with `res_valid`. The operand width is the parameter `W`, with a default of 8.

Top module: `magdiff_addsub`

## Requirements
- R1: With `op_sub`=0, the result is (A+B) mod 2^W, and the carry out of the top bit is discarded. Examples: FF+55 gives 54, FF+FF gives FE, AA+1D gives C7.
- R2: With `op_sub`=1 and A ≥ B, the result is A−B. Examples: (F6,21) gives D5, (FF,00) gives FF, (FF,55) gives AA.
- R3: With `op_sub`=1 and A < B, the result is B−A. This is the magnitude of the difference, not its wrapped value.
- R4: With `op_sub`=1 and A = B, the result is 0.
- R5: A pair sampled with `in_valid`=1 on a rising edge appears on `res` with `res_valid`=1 after exactly the second rising edge from that one. `res_valid` is 0 in every cycle for which no pair was accepted two edges earlier.
- R6: `rst_n` is a synchronous, active-low reset. A rising edge with `rst_n`=0 leaves `res_valid`=0 and `res`=0 and discards any pair in flight.
- R7: A cycle with `in_valid`=0 has no effect on the operands it presents. While `res_valid` is 0, `res` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair and mode are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = absolute difference |
| opnd_a | input | W | Operand A, unsigned |
| opnd_b | input | W | Operand B, unsigned |
| res_valid | output | 1 | `res` holds a new result this cycle |
| res | output | W | Sum or absolute difference |

## Verification
The assertions assume that `op_sub`, `opnd_a` and `opnd_b` are meaningful only in cycles where `in_valid` is high. A checker therefore keeps its own two-deep record of accepted pairs and compares `res` against unsigned arithmetic on that record.

The assertions also assume that reset is held low at time zero, before any operands arrive. The bench holds reset low for several edges before it drives anything. It changes inputs only on falling edges and deliberately presents junk operands with `in_valid` low.

The stimulus includes back-to-back accepted pairs in every cycle, covering all operand combinations in both modes. This exercises the pipeline with no idle gaps between results.

// File: rtl/magdiff_pkg.sv
// Shared majority-logic primitives for the absolute-difference adder/subtractor.
// Assumes nothing beyond two-valued logic.
package magdiff_pkg;

    // Three-input majority: the only gate besides inversion used below.
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (x & z);
    endfunction

    // XOR as OR(AND(~x,y), AND(x,~y)), where AND/OR are majorities with a tied input.
    function automatic logic mxor(input logic x, input logic y);
        return maj3(maj3(~x, y, 1'b0), maj3(x, ~y, 1'b0), 1'b1);
    endfunction

endpackage

// File: rtl/ctl_inverter.sv
// Controllable inverter: each output bit is the input bit XORed with ctl.
// ctl=0 passes the word unchanged, ctl=1 inverts it. Purely combinational.
module ctl_inverter #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    input  logic         ctl,
    output logic [W-1:0] dout
);
    import magdiff_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // One majority-built XOR per bit.
        always_comb dout[i] = mxor(din[i], ctl);
    end
endmodule

// File: rtl/ripple_adder.sv
// Ripple-carry adder of majority-logic full adders.
// Carry is a majority of the three inputs; sum is a two-level XOR. Combinational.
module ripple_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    import magdiff_pkg::*;

    logic [W:0] cy;

    // Chain input carry.
    always_comb cy[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        // Full adder for bit i.
        always_comb begin
            sum[i]  = mxor(mxor(x[i], y[i]), cy[i]);
            cy[i+1] = maj3(x[i], y[i], cy[i]);
        end
    end

    // Carry out of the top bit.
    always_comb cout = cy[W];
endmodule

// File: rtl/addsub_stage.sv
// One arithmetic stage: computes a + (b XOR {W{ctl}}) + ctl.
// With ctl=0 this is a+b; with ctl=1 it is a minus b in two's complement.
module addsub_stage #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ctl,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] b_cond;

    ctl_inverter #(.W(W)) u_inv (
        .din  (b),
        .ctl  (ctl),
        .dout (b_cond)
    );

    ripple_adder #(.W(W)) u_add (
        .x    (a),
        .y    (b_cond),
        .cin  (ctl),
        .sum  (sum),
        .cout (cout)
    );
endmodule

// File: rtl/magdiff_addsub.sv
// Absolute-difference adder/subtractor, two-stage pipeline.
// Stage 1 adds or subtracts and is registered. Stage 2 negates the stage-1
// value when subtracting and the stage-1 carry is low (B > A), then registers
// the result. A pair accepted with in_valid appears two edges later.
// Assumes: synchronous active-low reset; operands are qualified by in_valid.
module magdiff_addsub #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         op_sub,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic         res_valid,
    output logic [W-1:0] res
);
    logic [W-1:0] s1_sum;
    logic         s1_cout;
    logic [W-1:0] r1_sum;
    logic         r1_cout, r1_sub, r1_valid;
    logic         negate;
    logic [W-1:0] s2_sum;
    logic         s2_carry_unused;

    addsub_stage #(.W(W)) u_stage1 (
        .a    (opnd_a),
        .b    (opnd_b),
        .ctl  (op_sub),
        .sum  (s1_sum),
        .cout (s1_cout)
    );

    // Stage-1 pipeline register, loaded only for accepted pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1_valid <= 1'b0;
            r1_sum   <= '0;
            r1_cout  <= 1'b0;
            r1_sub   <= 1'b0;
        end else begin
            r1_valid <= in_valid;
            if (in_valid) begin
                r1_sum  <= s1_sum;
                r1_cout <= s1_cout;
                r1_sub  <= op_sub;
            end
        end
    end

    // Negate only for a subtraction that borrowed.
    always_comb negate = r1_sub & ~r1_cout;

    // Stage 2: 0 + (r1_sum XOR negate) + negate.
    addsub_stage #(.W(W)) u_stage2 (
        .a    ('0),
        .b    (r1_sum),
        .ctl  (negate),
        .sum  (s2_sum),
        .cout (s2_carry_unused)
    );

    // Output register; holds the last result between valid cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            res_valid <= r1_valid;
            if (r1_valid) res <= s2_sum;
        end
    end
endmodule

// File: rtl/magdiff_addsub_chk.sv
// Checker for magdiff_addsub. Keeps its own two-deep record of accepted pairs
// and compares the output against unsigned arithmetic on that record.
// Assumes reset is asserted at time zero.
module magdiff_addsub_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         op_sub,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         res_valid,
    input logic [W-1:0] res
);
    logic         p_v1, p_v2, p_s1, p_s2, primed;
    logic [W-1:0] p_a1, p_a2, p_b1, p_b2;

    // Record accepted pairs two deep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_v1 <= 1'b0; p_v2 <= 1'b0; p_s1 <= 1'b0; p_s2 <= 1'b0; primed <= 1'b0;
            p_a1 <= '0; p_a2 <= '0; p_b1 <= '0; p_b2 <= '0;
        end else begin
            primed <= 1'b1;
            p_v1 <= in_valid;
            p_v2 <= p_v1;
            if (in_valid) begin p_a1 <= opnd_a; p_b1 <= opnd_b; p_s1 <= op_sub; end
            if (p_v1) begin p_a2 <= p_a1; p_b2 <= p_b1; p_s2 <= p_s1; end
        end
    end

    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == p_v2);

    assert_add_wraps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !p_s2) |-> res == W'(p_a2 + p_b2));

    assert_sub_ge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && p_s2 && p_a2 >= p_b2) |-> res == W'(p_a2 - p_b2));

    assert_sub_lt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && p_s2 && p_a2 < p_b2) |-> res == W'(p_b2 - p_a2));

    assert_sub_equal_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && p_s2 && p_a2 == p_b2) |-> res == '0);

    assert_reset_clears_R6: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && res == '0));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !p_v2) |-> $stable(res));
endmodule

bind magdiff_addsub magdiff_addsub_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sub    (op_sub),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .res_valid (res_valid),
    .res       (res)
);

// File: tb/magdiff_addsub_tb.sv
// Directed bench for magdiff_addsub: one task per scenario, each checking itself.
// Inputs change on falling edges; outputs are sampled on falling edges.
module magdiff_addsub_tb;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG_CYCLES = 180000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op_sub = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         res_valid;
    logic [W-1:0] res;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    magdiff_addsub #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid), .res(res)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Independent reference from the requirements.
    function automatic logic [W-1:0] ref_model(input logic [W-1:0] a, input logic [W-1:0] b,
                                               input logic sub);
        if (!sub) return W'(a + b);
        return (a >= b) ? W'(a - b) : W'(b - a);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one pair, wait two edges, compare value and valid.
    task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic sub, input string req);
        logic [W-1:0] e;
        e = ref_model(a, b, sub);
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sub = sub; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(!res_valid, {req, " (R5 valid early)"}, {7'd0, res_valid}, '0);
        @(negedge clk);
        chk(res_valid, {req, " (R5 valid)"}, {7'd0, res_valid}, 8'd1);
        chk(res == e, req, res, e);
    endtask

    // R6: reset state, and reset discarding a pair in flight.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!res_valid && res == '0, "R6 reset state", res, '0);
        rst_n = 1'b1;
        run_one(8'h12, 8'h34, 1'b0, "R1 pre-reset");
        @(negedge clk);
        opnd_a = 8'h77; opnd_b = 8'h11; op_sub = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(!res_valid && res == '0, "R6 in-flight discarded", res, '0);
        @(negedge clk);
        chk(!res_valid, "R6 no late valid", {7'd0, res_valid}, '0);
    endtask

    task automatic t_add_vectors();
        run_one(8'hFF, 8'h55, 1'b0, "R1 FF+55");
        run_one(8'hFF, 8'hFF, 1'b0, "R1 FF+FF");
        run_one(8'hAA, 8'h1D, 1'b0, "R1 AA+1D");
        run_one(8'h00, 8'h00, 1'b0, "R1 0+0");
    endtask

    task automatic t_sub_vectors();
        run_one(8'hF6, 8'h21, 1'b1, "R2 F6-21");
        run_one(8'hFF, 8'h00, 1'b1, "R2 FF-00");
        run_one(8'hFF, 8'h55, 1'b1, "R2 FF-55");
    endtask

    task automatic t_sub_lt();
        run_one(8'h21, 8'hF6, 1'b1, "R3 |21-F6|");
        run_one(8'h00, 8'hFF, 1'b1, "R3 |00-FF|");
        run_one(8'h7F, 8'h80, 1'b1, "R3 |7F-80|");
    endtask

    task automatic t_equal();
        run_one(8'h00, 8'h00, 1'b1, "R4 00-00");
        run_one(8'h80, 8'h80, 1'b1, "R4 80-80");
        run_one(8'hFF, 8'hFF, 1'b1, "R4 FF-FF");
    endtask

    // R7: idle cycles with junk operands leave res and res_valid untouched.
    task automatic t_hold();
        run_one(8'h40, 8'h03, 1'b1, "R2 before hold");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!res_valid && res == 8'h3D, "R7 hold", res, 8'h3D);
            opnd_a = 8'(k * 37 + 5); opnd_b = 8'(k * 91 + 200); op_sub = k[0];
            in_valid = 1'b0;
        end
        repeat (2) @(negedge clk);
        chk(!res_valid && res == 8'h3D, "R7 hold after junk", res, 8'h3D);
    endtask

    // Back-to-back exhaustive sweep for one mode; checks stream two cycles behind.
    task automatic t_sweep(input logic sub);
        localparam int TOTAL = 1 << (2 * W);
        logic [W-1:0] ha [2];
        logic [W-1:0] hb [2];
        logic         hv [2];
        logic [W-1:0] e;
        hv[0] = 1'b0; hv[1] = 1'b0;
        for (int i = 0; i < TOTAL + 2; i++) begin
            @(negedge clk);
            if (hv[1]) begin
                e = ref_model(ha[1], hb[1], sub);
                chk(res_valid && res == e,
                    !sub ? "R1 sweep" : (ha[1] >= hb[1] ? "R2 sweep" : "R3 sweep"), res, e);
            end
            ha[1] = ha[0]; hb[1] = hb[0]; hv[1] = hv[0];
            if (i < TOTAL) begin
                opnd_a = W'(i >> W); opnd_b = W'(i); op_sub = sub; in_valid = 1'b1;
                ha[0] = opnd_a; hb[0] = opnd_b; hv[0] = 1'b1;
            end else begin
                in_valid = 1'b0; hv[0] = 1'b0;
            end
        end
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc >= WATCHDOG_CYCLES) begin
                n_checks++; n_fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG_CYCLES);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_add_vectors();
        t_sub_vectors();
        t_sub_lt();
        t_equal();
        t_hold();
        t_sweep(1'b0);
        t_sweep(1'b1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule